// File: doc/BRIEF.md
# Configurable FIFO Word Packer

This block sits between a 32-bit FIFO entry and a serial shifter that works on chunks of at most eight bits. Four 10-bit step descriptors, supplied on two 20-bit configuration inputs, say which bit field of the FIFO word forms each chunk. A descriptor gives the field's start index, the direction in which it grows from that index, its length, and whether it is the last step for the word. Because every step is programmable, the block handles odd word sizes and either bit order without fixed byte lanes.

On the transmit side a FIFO word is captured and split into one chunk per step. Each chunk is handed downstream under a valid/ready handshake. On the receive side incoming chunks are written into their fields of an assembly register, and the finished word is offered to the FIFO under its own handshake. Both sides read the same descriptors and run at the same time without depending on each other. A small decoder also turns a 2-bit granularity code into the number of protocol words held in one FIFO entry.

Top module: `fifo_word_packer`

## Requirements
- R1: Each 10-bit descriptor is laid out as follows: bit 0 is the last-step flag, bits 3:1 hold the field length minus one, bit 4 is the direction and bits 9:5 are the start index. Descriptor 0 is in `pack_cfg_lo[9:0]`, descriptor 1 in `pack_cfg_lo[19:10]`, descriptor 2 in `pack_cfg_hi[9:0]` and descriptor 3 in `pack_cfg_hi[19:10]`. `chunk_len_m1` shows bits 3:1 of the active descriptor.
- R2: A transmit chunk is its field, right-aligned. With direction 1 the field runs from the start index down to start minus length-minus-one. With direction 0 it runs from the start index up. Bit indices wrap modulo 32. `chunk_msb_first` equals the direction bit of the active descriptor.
- R3: Chunk bits above the field length are zero.
- R4: For each word the transmit side uses descriptors in the order 0, 1, 2, 3. It stops after the first descriptor whose last-step flag is 1, or after descriptor 3 if none has the flag set.
- R5: `tx_word_ready` is high exactly when no word is in progress. While a chunk waits for `chunk_ready`, the chunk and its length are held unchanged. After the final chunk is accepted, `tx_word_ready` rises in the next cycle.
- R6: The receive side writes the valid bits of each chunk into that step's field, using the same mapping as R2. Every bit of the assembled word that no step writes is zero. Chunk bits above the field length are not used.
- R7: After the chunk of the final step (by the rule in R4) is accepted, `rx_word_valid` rises in the next cycle. While a word is offered, `rx_chunk_ready` is low and `rx_word` is held until `rx_word_ready` is high.
- R8: The granularity decode gives 4 words per entry for code 0, 2 for code 1 and 1 for code 2, each with `gran_ok` = 1. Code 3 gives 0 words per entry with `gran_ok` = 0.
- R9: After reset, `tx_word_ready` = 1, `chunk_valid` = 0, `rx_chunk_ready` = 1 and `rx_word_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pack_cfg_lo | input | 20 | Descriptors 0 and 1 |
| pack_cfg_hi | input | 20 | Descriptors 2 and 3 |
| gran_code | input | 2 | Byte-granularity code |
| words_per_entry | output | 3 | Decoded protocol words per FIFO entry |
| gran_ok | output | 1 | Granularity code is defined |
| tx_word | input | 32 | FIFO word to split |
| tx_word_valid | input | 1 | tx_word is present |
| tx_word_ready | output | 1 | Word is taken this cycle if valid |
| chunk_data | output | 8 | Extracted chunk, right-aligned |
| chunk_len_m1 | output | 3 | Chunk length minus one |
| chunk_msb_first | output | 1 | Serial order hint for the shifter |
| chunk_valid | output | 1 | chunk_data is present |
| chunk_ready | input | 1 | Downstream takes the chunk |
| rx_chunk | input | 8 | Incoming chunk, right-aligned |
| rx_chunk_valid | input | 1 | rx_chunk is present |
| rx_chunk_ready | output | 1 | Chunk is taken this cycle if valid |
| rx_word | output | 32 | Assembled FIFO word |
| rx_word_valid | output | 1 | rx_word is complete |
| rx_word_ready | input | 1 | FIFO takes the word |

## Verification
The transmit split and the receive assembly share the descriptor inputs and can both advance in the same cycle. One side can also finish a word on the same edge that the other side starts one. The bench drives both sides together, with valid and ready signals toggled at random, so these coincidences happen often under every descriptor set. It includes sets that wrap around bit 31, sets with no last-step flag, and sets whose flag is on descriptor 0. A behavioural model built from queues of pending words and integer indices predicts each port value, and the bench compares the port against that prediction on every clock.

// File: rtl/fifo_word_packer.sv
module fifo_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] pack_cfg_lo,
  input  logic [19:0] pack_cfg_hi,
  input  logic [1:0]  gran_code,
  output logic [2:0]  words_per_entry,
  output logic        gran_ok,
  input  logic [31:0] tx_word,
  input  logic        tx_word_valid,
  output logic        tx_word_ready,
  output logic [7:0]  chunk_data,
  output logic [2:0]  chunk_len_m1,
  output logic        chunk_msb_first,
  output logic        chunk_valid,
  input  logic        chunk_ready,
  input  logic [7:0]  rx_chunk,
  input  logic        rx_chunk_valid,
  output logic        rx_chunk_ready,
  output logic [31:0] rx_word,
  output logic        rx_word_valid,
  input  logic        rx_word_ready
);

  localparam int STEPS  = 4;
  localparam int CHUNK  = 8;
  localparam int IDX_W  = 5;
  localparam int STEP_W = $clog2(STEPS);

  logic [9:0] vec [STEPS];
  assign vec[0] = pack_cfg_lo[9:0];
  assign vec[1] = pack_cfg_lo[19:10];
  assign vec[2] = pack_cfg_hi[9:0];
  assign vec[3] = pack_cfg_hi[19:10];

  // transmit split
  logic              tx_busy;
  logic [STEP_W-1:0] tx_step;
  logic [31:0]       tx_hold;
  logic [9:0]        tv;
  logic [IDX_W-1:0]  t_base;
  logic              t_last;
  logic [CHUNK-1:0]  t_raw;

  assign tv     = vec[tx_step];
  assign t_base = tv[4] ? tv[9:5] - {2'b00, tv[3:1]} : tv[9:5];
  assign t_last = tv[0] | (tx_step == STEP_W'(STEPS-1));

  always_comb begin
    for (int j = 0; j < CHUNK; j++)
      t_raw[j] = (3'(j) <= tv[3:1]) ? tx_hold[t_base + IDX_W'(j)] : 1'b0;
  end

  assign tx_word_ready   = !tx_busy;
  assign chunk_valid     = tx_busy;
  assign chunk_data      = t_raw;
  assign chunk_len_m1    = tv[3:1];
  assign chunk_msb_first = tv[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_step <= '0;
      tx_hold <= '0;
    end else if (!tx_busy) begin
      if (tx_word_valid) begin
        tx_hold <= tx_word;
        tx_busy <= 1'b1;
        tx_step <= '0;
      end
    end else if (chunk_ready) begin
      if (t_last) begin
        tx_busy <= 1'b0;
        tx_step <= '0;
      end else begin
        tx_step <= tx_step + 1'b1;
      end
    end
  end

  // receive assembly
  logic              rx_full;
  logic [STEP_W-1:0] rx_step;
  logic [31:0]       rx_acc;
  logic [31:0]       rx_next;
  logic [9:0]        rv;
  logic [IDX_W-1:0]  r_base;
  logic              r_last;

  assign rv     = vec[rx_step];
  assign r_base = rv[4] ? rv[9:5] - {2'b00, rv[3:1]} : rv[9:5];
  assign r_last = rv[0] | (rx_step == STEP_W'(STEPS-1));

  always_comb begin
    rx_next = rx_acc;
    for (int j = 0; j < CHUNK; j++)
      if (3'(j) <= rv[3:1]) rx_next[r_base + IDX_W'(j)] = rx_chunk[j];
  end

  assign rx_chunk_ready = !rx_full;
  assign rx_word_valid  = rx_full;
  assign rx_word        = rx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_step <= '0;
      rx_acc  <= '0;
    end else if (rx_full) begin
      if (rx_word_ready) begin
        rx_full <= 1'b0;
        rx_acc  <= '0;
      end
    end else if (rx_chunk_valid) begin
      rx_acc <= rx_next;
      if (r_last) begin
        rx_full <= 1'b1;
        rx_step <= '0;
      end else begin
        rx_step <= rx_step + 1'b1;
      end
    end
  end

  // granularity decode
  always_comb begin
    gran_ok = 1'b1;
    case (gran_code)
      2'd0:    words_per_entry = 3'd4;
      2'd1:    words_per_entry = 3'd2;
      2'd2:    words_per_entry = 3'd1;
      default: begin
        words_per_entry = 3'd0;
        gran_ok         = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fifo_word_packer_chk.sv
module fifo_word_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  gran_code,
  input logic [2:0]  words_per_entry,
  input logic        gran_ok,
  input logic        tx_word_ready,
  input logic [7:0]  chunk_data,
  input logic [2:0]  chunk_len_m1,
  input logic        chunk_valid,
  input logic        chunk_ready,
  input logic        rx_chunk_ready,
  input logic [31:0] rx_word,
  input logic        rx_word_valid,
  input logic        rx_word_ready
);

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (((chunk_data >> chunk_len_m1) >> 1) == 8'd0));

  p_no_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> !tx_word_ready);

  p_chunk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_data) && $stable(chunk_len_m1));

  p_rx_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |-> !rx_chunk_ready);

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid && !rx_word_ready |=> rx_word_valid && $stable(rx_word));

  p_gran_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gran_code == 2'd3 |-> !gran_ok && words_per_entry == 3'd0);

endmodule

bind fifo_word_packer fifo_word_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gran_code(gran_code), .words_per_entry(words_per_entry),
  .gran_ok(gran_ok), .tx_word_ready(tx_word_ready), .chunk_data(chunk_data),
  .chunk_len_m1(chunk_len_m1), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
  .rx_chunk_ready(rx_chunk_ready), .rx_word(rx_word), .rx_word_valid(rx_word_valid),
  .rx_word_ready(rx_word_ready)
);

// File: tb/fifo_word_packer_test.sv
module fifo_word_packer_test;
  logic clk = 0, rst_n = 0;
  logic [19:0] pack_cfg_lo = '0, pack_cfg_hi = '0;
  logic [1:0] gran_code = '0;
  logic [2:0] words_per_entry;
  logic gran_ok;
  logic [31:0] tx_word = '0;
  logic tx_word_valid = 0, tx_word_ready;
  logic [7:0] chunk_data;
  logic [2:0] chunk_len_m1;
  logic chunk_msb_first, chunk_valid, chunk_ready = 1;
  logic [7:0] rx_chunk = '0;
  logic rx_chunk_valid = 0, rx_chunk_ready;
  logic [31:0] rx_word;
  logic rx_word_valid, rx_word_ready = 1;

  int checks = 0, errors = 0;
  bit done = 0, en = 0;
  bit tx_took = 0, rx_took = 0;

  bit m_tbusy = 0, m_rfull = 0;
  int m_tstep = 0, m_rstep = 0;
  logic [31:0] m_tword = '0, m_acc = '0;

  always #10 clk = ~clk;

  fifo_word_packer uut (.*);

  function automatic logic [9:0] mkv(int s, bit d, int lm1, bit stp);
    return {5'(s), d, 3'(lm1), stp};
  endfunction

  function automatic logic [9:0] m_vec(int i);
    case (i)
      0: return pack_cfg_lo[9:0];
      1: return pack_cfg_lo[19:10];
      2: return pack_cfg_hi[9:0];
      default: return pack_cfg_hi[19:10];
    endcase
  endfunction

  function automatic int m_lo(logic [9:0] v);
    int len = int'(v[3:1]) + 1;
    int s = int'(v[9:5]);
    return v[4] ? s - (len - 1) : s;
  endfunction

  function automatic logic [7:0] m_extract(logic [31:0] w, logic [9:0] v);
    logic [7:0] r = '0;
    int lo = m_lo(v);
    for (int j = 0; j <= int'(v[3:1]); j++) r[j] = w[(lo + j + 32) % 32];
    return r;
  endfunction

  function automatic logic [31:0] m_insert(logic [31:0] w, logic [7:0] c, logic [9:0] v);
    logic [31:0] r = w;
    int lo = m_lo(v);
    for (int j = 0; j <= int'(v[3:1]); j++) r[(lo + j + 32) % 32] = c[j];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tbusy = 0; m_rfull = 0; m_tstep = 0; m_rstep = 0; m_acc = '0; m_tword = '0;
    end else begin
      if (!m_tbusy) begin
        if (tx_word_valid) begin
          m_tword = tx_word; m_tbusy = 1; m_tstep = 0; tx_took = 1;
        end
      end else if (chunk_ready) begin
        if (m_vec(m_tstep)[0] || m_tstep == 3) begin m_tbusy = 0; m_tstep = 0; end
        else m_tstep++;
      end
      if (m_rfull) begin
        if (rx_word_ready) begin m_rfull = 0; m_acc = '0; end
      end else if (rx_chunk_valid) begin
        rx_took = 1;
        m_acc = m_insert(m_acc, rx_chunk, m_vec(m_rstep));
        if (m_vec(m_rstep)[0] || m_rstep == 3) begin m_rfull = 1; m_rstep = 0; end
        else m_rstep++;
      end
    end
  end

  task automatic compare_all();
    chk("R5 tx_word_ready", 32'(tx_word_ready), 32'(!m_tbusy));
    chk("R4 chunk_valid", 32'(chunk_valid), 32'(m_tbusy));
    if (m_tbusy) begin
      chk("R2 R3 chunk_data", 32'(chunk_data), 32'(m_extract(m_tword, m_vec(m_tstep))));
      chk("R1 chunk_len_m1", 32'(chunk_len_m1), 32'(m_vec(m_tstep)[3:1]));
      chk("R2 chunk_msb_first", 32'(chunk_msb_first), 32'(m_vec(m_tstep)[4]));
    end
    chk("R7 rx_chunk_ready", 32'(rx_chunk_ready), 32'(!m_rfull));
    chk("R7 rx_word_valid", 32'(rx_word_valid), 32'(m_rfull));
    if (m_rfull) chk("R6 rx_word", rx_word, m_acc);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    if (!tx_word_valid || tx_took) begin
      tx_word_valid = en && ($urandom % 4 != 0);
      tx_word = $urandom;
    end
    tx_took = 0;
    if (!rx_chunk_valid || rx_took) begin
      rx_chunk_valid = en && ($urandom % 4 != 0);
      rx_chunk = 8'($urandom);
    end
    rx_took = 0;
    chunk_ready   = en ? ($urandom % 3 != 0) : 1'b1;
    rx_word_ready = en ? ($urandom % 3 != 0) : 1'b1;
  endtask

  task automatic run_phase(logic [19:0] lo, logic [19:0] hi, int n);
    pack_cfg_lo = lo; pack_cfg_hi = hi;
    en = 1;
    repeat (n) cycle();
    en = 0;
    for (int k = 0; k < 200; k++) begin
      if (!m_tbusy && !m_rfull && !tx_word_valid && !rx_chunk_valid) break;
      cycle();
    end
    cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset tx_word_ready", 32'(tx_word_ready), 32'd1);
    chk("R9 reset chunk_valid", 32'(chunk_valid), 32'd0);
    chk("R9 reset rx_chunk_ready", 32'(rx_chunk_ready), 32'd1);
    chk("R9 reset rx_word_valid", 32'(rx_word_valid), 32'd0);

    for (int g = 0; g < 4; g++) begin
      gran_code = 2'(g);
      #1;
      chk("R8 words_per_entry", 32'(words_per_entry), (g == 3) ? 32'd0 : 32'(4 >> g));
      chk("R8 gran_ok", 32'(gran_ok), (g == 3) ? 32'd0 : 32'd1);
    end

    // four 7-bit words, MSB first
    run_phase({mkv(14,1,6,0), mkv(6,1,6,0)}, {mkv(30,1,6,1), mkv(22,1,6,0)}, 600);
    // one 23-bit word, MSB first, last step on descriptor 2
    run_phase({mkv(14,1,7,0), mkv(22,1,7,0)}, {mkv(0,0,0,0), mkv(6,1,6,1)}, 600);
    // two 15-bit words, LSB first
    run_phase({mkv(8,0,6,0), mkv(0,0,7,0)}, {mkv(24,0,6,1), mkv(16,0,7,0)}, 600);
    // no last-step flag, fields wrapping past bit 31
    run_phase({mkv(3,1,7,0), mkv(28,0,7,0)}, {mkv(31,0,0,0), mkv(12,1,2,0)}, 600);
    // last step on descriptor 0
    run_phase({mkv(9,1,3,0), mkv(5,0,7,1)}, {mkv(20,0,4,0), mkv(17,1,3,0)}, 600);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule